// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external machine cycles of a small 8-bit processor core on a bus where the low address byte and the data byte share one set of pins. The core gives it one request at a time: a cycle kind, a 16-bit address and, for writes, a data byte. The sequencer then steps through the bus states one T-state at a time. It places the address during the first T-state and marks it with an address strobe. It drives the read or write strobe during the data phase. It returns the captured byte with a one-clock done pulse.

The T-state rate is the input clock divided by a parameter (two by default). Slow targets stretch a cycle by holding `ready` low, which adds wait states. An external master takes the bus with `hold`. The sequencer finishes any cycle in flight, then answers with `hlda` and withdraws its drivers until `hold` is released. Three-state pins are modelled as output enables: `ad_oe` for the shared byte lanes, and `bus_oe` for the high address byte, the strobes and the memory/IO select.

Top module: `mux_bus_seq`

## Requirements
- R1: While reset is applied the block shows an idle bus: `ale`=0, `rd_n`=`wr_n`=1, `ad_oe`=0, `bus_oe`=1, `hlda`=0, `{s1,s0}`=00, `io_m`=0, and `req_accept`=`rsp_done`=0.
- R2: One T-state lasts CLK_DIV clocks (2 by default). `ale` is high for exactly the first T-state of every cycle. During that T-state `{a_hi,ad_out}` carries the cycle address with `ad_oe`=1.
- R3: Measured from the `req_accept` pulse to the `rsp_done` pulse, an opcode fetch takes 4 T-states. Memory read, memory write, IO read and IO write each take 3 T-states.
- R4: `req_kind` codes are 0 fetch, 1 memory read, 2 memory write, 3 IO read, 4 IO write. `{s1,s0}` is 11 for a fetch, 10 for either read and 01 for either write, held for the whole cycle.
- R5: `io_m` is 0 for fetch and memory cycles and 1 for IO cycles. An IO cycle places `req_addr[7:0]` on both `ad_out` and `a_hi`.
- R6: In a fetch or read, `rd_n` is low from the second T-state through the third, including any wait states. `ad_oe` is 0 while `rd_n` is low and `wr_n` stays 1. The byte on `ad_in` at the end of the third T-state is returned on `rsp_rdata` with `rsp_done`.
- R7: In a write, `wr_n` is low from the second T-state through the third, including any wait states. During that time `ad_out` holds `req_wdata` with `ad_oe`=1, and `rd_n` stays 1.
- R8: `ready` is sampled at the end of the second T-state and at the end of each wait state. Each sample taken low adds one wait T-state before the third T-state.
- R9: A `hold` raised during a cycle lets that cycle finish. `hlda` rises at the next T-state boundary after `rsp_done`. While `hlda` is 1, `bus_oe`=0, `ad_oe`=0 and no request is accepted.
- R10: When `hold` drops, `hlda` falls at the next T-state boundary, and a request that waited meanwhile is then accepted and run normally.
- R11: The fourth T-state of an opcode fetch keeps `rd_n` high and `ad_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, divided to form T-states |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is pending; hold until accepted |
| req_kind | input | 3 | Cycle kind code (R4) |
| req_addr | input | 16 | Cycle address; bits 7:0 are the port for IO |
| req_wdata | input | 8 | Byte for write cycles |
| req_accept | output | 1 | One-clock pulse when the request is taken |
| rsp_done | output | 1 | One-clock pulse when the cycle ends |
| rsp_rdata | output | 8 | Byte captured by the last fetch or read |
| ad_out | output | 8 | Shared lanes, outgoing: low address or write data |
| ad_in | input | 8 | Shared lanes, incoming read data |
| ad_oe | output | 1 | Drive enable for the shared lanes |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for IO cycles, 0 for memory cycles |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| ready | input | 1 | Target ready; low inserts wait states |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus handed over |
| bus_oe | output | 1 | Drive enable for a_hi, strobes and io_m |

## Verification
Every cycle kind is issued at low, high and all-zero/all-one addresses, with zero, one, two and three wait states. Matching clock counts against the kind separates the four-state fetch from the three-state cycles, and it also shows whether `ready` is sampled once per T-state. Reads use an address-dependent target model and a filler value off the read phase, so a capture made in the wrong T-state, or from the wrong address, returns a different byte. IO cycles are checked for the port number on both address bytes. A hold raised in the middle of a wait-stretched read, with a second request queued behind it, separates "finish then grant" from both "grant at once" and "never grant".

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  // cycle kinds as seen on req_kind
  localparam logic [2:0] CY_FETCH = 3'd0;
  localparam logic [2:0] CY_MRD   = 3'd1;
  localparam logic [2:0] CY_MWR   = 3'd2;
  localparam logic [2:0] CY_IORD  = 3'd3;
  localparam logic [2:0] CY_IOWR  = 3'd4;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_TW   = 3'd3,
    TS_T3   = 3'd4,
    TS_T4   = 3'd5,
    TS_HOLD = 3'd6
  } tstate_e;

  function automatic logic cyc_is_write(input logic [2:0] k);
    return (k == CY_MWR) || (k == CY_IOWR);
  endfunction

  function automatic logic cyc_is_io(input logic [2:0] k);
    return (k == CY_IORD) || (k == CY_IOWR);
  endfunction

  // status pair {s1,s0}
  function automatic logic [1:0] cyc_status(input logic [2:0] k);
    logic [1:0] s;
    if (k == CY_FETCH)       s = 2'b11;
    else if (cyc_is_write(k)) s = 2'b01;
    else                      s = 2'b10;
    return s;
  endfunction

endpackage

// File: rtl/mbs_tick.sv
module mbs_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/mbs_seq.sv
module mbs_seq
  import mbs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          ready,
  input  logic          hold,
  input  logic [DW-1:0] ad_in,
  output tstate_e       st,
  output logic [2:0]    cur_kind,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] cur_wdata,
  output logic          req_accept,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata
);
  tstate_e       st_q, st_d;
  logic [2:0]    kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          acc_q, done_q;
  logic          take, finish, capture;

  // next T-state; applied only on a T-state boundary (tick)
  always_comb begin
    st_d    = st_q;
    take    = 1'b0;
    finish  = 1'b0;
    capture = 1'b0;
    case (st_q)
      TS_IDLE: begin
        if (hold) st_d = TS_HOLD;
        else if (req_valid) begin
          st_d = TS_T1;
          take = 1'b1;
        end
      end
      TS_T1: st_d = TS_T2;
      TS_T2, TS_TW: st_d = ready ? TS_T3 : TS_TW;
      TS_T3: begin
        capture = !cyc_is_write(kind_q);
        if (kind_q == CY_FETCH) st_d = TS_T4;
        else begin
          st_d   = TS_IDLE;
          finish = 1'b1;
        end
      end
      TS_T4: begin
        st_d   = TS_IDLE;
        finish = 1'b1;
      end
      TS_HOLD: if (!hold) st_d = TS_IDLE;
      default: st_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TS_IDLE;
      kind_q  <= CY_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (tick) begin
      st_q <= st_d;
      if (take) begin
        kind_q  <= req_kind;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= ad_in;
    end
  end

  // single-clock pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= tick && take;
      done_q <= tick && finish;
    end
  end

  assign st         = st_q;
  assign cur_kind   = kind_q;
  assign cur_addr   = addr_q;
  assign cur_wdata  = wdata_q;
  assign req_accept = acc_q;
  assign rsp_done   = done_q;
  assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
  import mbs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  tstate_e          st,
  input  logic [2:0]       kind,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] a_hi,
  output logic             io_m,
  output logic             s1,
  output logic             s0,
  output logic             hlda,
  output logic             bus_oe
);
  localparam int HW = AW - DW;

  logic active, strobe, is_wr, is_io;
  logic [1:0] stat;

  always_comb begin
    active = (st == TS_T1) || (st == TS_T2) || (st == TS_TW) ||
             (st == TS_T3) || (st == TS_T4);
    strobe = (st == TS_T2) || (st == TS_TW) || (st == TS_T3);
    is_wr  = cyc_is_write(kind);
    is_io  = cyc_is_io(kind);
    stat   = cyc_status(kind);

    ale    = (st == TS_T1);
    rd_n   = !(strobe && !is_wr);
    wr_n   = !(strobe && is_wr);
    ad_oe  = ale || (strobe && is_wr);

    if (ale)                  ad_out = addr[DW-1:0];
    else if (strobe && is_wr) ad_out = wdata;
    else                      ad_out = '0;

    if (!active)    a_hi = '0;
    else if (is_io) a_hi = HW'(addr[DW-1:0]);
    else            a_hi = addr[AW-1:DW];

    io_m   = active && is_io;
    s1     = active && stat[1];
    s0     = active && stat[0];
    hlda   = (st == TS_HOLD);
    bus_oe = (st != TS_HOLD);
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int CLK_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_accept,
  output logic             rsp_done,
  output logic [DW-1:0]    rsp_rdata,
  output logic [DW-1:0]    ad_out,
  input  logic [DW-1:0]    ad_in,
  output logic             ad_oe,
  output logic [AW-DW-1:0] a_hi,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             io_m,
  output logic             s1,
  output logic             s0,
  input  logic             ready,
  input  logic             hold,
  output logic             hlda,
  output logic             bus_oe
);
  logic [1:0]    rsync_q;
  logic          core_rst_n;
  logic          tick;
  tstate_e       st;
  logic [2:0]    cur_kind;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  mbs_tick #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(core_rst_n),
    .tick (tick)
  );

  mbs_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .tick      (tick),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ready     (ready),
    .hold      (hold),
    .ad_in     (ad_in),
    .st        (st),
    .cur_kind  (cur_kind),
    .cur_addr  (cur_addr),
    .cur_wdata (cur_wdata),
    .req_accept(req_accept),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
  );

  mbs_pins #(.AW(AW), .DW(DW)) u_pins (
    .st    (st),
    .kind  (cur_kind),
    .addr  (cur_addr),
    .wdata (cur_wdata),
    .ale   (ale),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .ad_out(ad_out),
    .ad_oe (ad_oe),
    .a_hi  (a_hi),
    .io_m  (io_m),
    .s1    (s1),
    .s0    (s0),
    .hlda  (hlda),
    .bus_oe(bus_oe)
  );
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ale,
  input logic          rd_n,
  input logic          wr_n,
  input logic          ad_oe,
  input logic [DW-1:0] ad_out,
  input logic          s1,
  input logic          s0,
  input logic          io_m,
  input logic          hlda,
  input logic          bus_oe,
  input logic          req_accept,
  input logic          rsp_done
);
  // R2: address phase never overlaps a strobe, lanes driven
  a_r2_ale_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && rd_n && wr_n));

  // R6: read strobe means lanes released and no write strobe
  a_r6_read_lanes_free: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!ad_oe && wr_n));

  // R4: status and select stay put across the read phase
  a_r4_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n)) |-> $stable({s1, s0, io_m}));

  // R7: write data steady while the write strobe is low
  a_r7_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> ($stable(ad_out) && ad_oe));

  // R3: done is a single-clock pulse with strobes already released
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r3_done_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (rd_n && wr_n && !ale));

  // R9: handed-over bus is fully released and takes no request
  a_r9_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!bus_oe && !ad_oe && !req_accept));

  // R10: hold ends only on a boundary with the bus idle
  a_r10_hold_exit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda) |-> (bus_oe && !ale && rd_n && wr_n));
endmodule

bind mux_bus_seq mbs_checker #(.DW(DW)) u_mbs_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_oe     (ad_oe),
  .ad_out    (ad_out),
  .s1        (s1),
  .s0        (s0),
  .io_m      (io_m),
  .hlda      (hlda),
  .bus_oe    (bus_oe),
  .req_accept(req_accept),
  .rsp_done  (rsp_done)
);

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;
  localparam int AW = 16;
  localparam int DW = 8;

  localparam logic [2:0] K_FETCH = 3'd0;
  localparam logic [2:0] K_MRD   = 3'd1;
  localparam logic [2:0] K_MWR   = 3'd2;
  localparam logic [2:0] K_IORD  = 3'd3;
  localparam logic [2:0] K_IOWR  = 3'd4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, req_valid, req_accept, rsp_done, ad_oe, ale, rd_n, wr_n;
  logic          io_m, s1, s0, ready, hold, hlda, bus_oe;
  logic [2:0]    req_kind;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, ad_out, ad_in, a_hi;

  mux_bus_seq i_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_accept(req_accept),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ad_out(ad_out), .ad_in(ad_in),
    .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .io_m(io_m), .s1(s1), .s0(s0), .ready(ready), .hold(hold), .hlda(hlda),
    .bus_oe(bus_oe)
  );

  typedef struct {
    logic [2:0]  kind;
    logic [15:0] addr;
    logic [7:0]  wdata;
    int          waits;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // target model: data depends on every address bit and on space
  function automatic logic [7:0] tgt_data(input logic [15:0] a, input logic io);
    return a[15:8] ^ {a[6:0], a[7]} ^ (io ? 8'h3C : 8'hA5);
  endfunction

  logic [15:0] lat_addr = 16'h0;
  logic        lat_io   = 1'b0;
  assign ad_in = !rd_n ? tgt_data(lat_addr, lat_io) : 8'hEE;

  // ready generator: low for 2*wait_k strobe clocks
  int wait_k = 0;
  int low_cnt = 0;
  initial ready = 1'b1;
  always @(negedge clk) begin
    if (req_accept) low_cnt = 0;
    if ((!rd_n || !wr_n) && low_cnt < 2 * wait_k) begin
      ready = 1'b0;
      low_cnt++;
    end else begin
      ready = 1'b1;
    end
    if (ale) begin
      lat_addr = {a_hi, ad_out};
      lat_io   = io_m;
    end
  end

  // monitor / scoreboard
  bit          busy = 1'b0;
  int          cnt, ale_cnt, rd_cnt, wr_cnt, oe_cnt, hl_cnt, wd_bad;
  logic [15:0] seen_addr;
  logic [2:0]  seen_st;
  logic [7:0]  wd_seen;
  exp_t        e;
  int          tst;
  logic        e_io;
  logic [15:0] e_addr;
  logic [1:0]  e_stat;

  always @(negedge clk) begin
    if (req_accept) begin
      busy = 1'b1; cnt = 0; ale_cnt = 0; rd_cnt = 0; wr_cnt = 0;
      oe_cnt = 0; hl_cnt = 0; wd_bad = 0; wd_seen = 8'h00;
      seen_addr = 16'h0; seen_st = 3'b0;
    end else if (busy) cnt++;
    if (busy) begin
      if (ale) begin
        ale_cnt++;
        seen_addr = {a_hi, ad_out};
        seen_st   = {s1, s0, io_m};
      end
      if (!rd_n) rd_cnt++;
      if (!wr_n) begin
        wr_cnt++;
        wd_seen = ad_out;
        if (!ad_oe) wd_bad++;
      end
      if (ad_oe) oe_cnt++;
      if (hlda) hl_cnt++;
    end
    if (rsp_done) begin
      chk(busy && q.size() > 0, "R3 done without request", q.size(), 1);
      if (q.size() > 0) begin
        e      = q.pop_front();
        e_io   = (e.kind == K_IORD) || (e.kind == K_IOWR);
        e_addr = e_io ? {e.addr[7:0], e.addr[7:0]} : e.addr;
        e_stat = (e.kind == K_FETCH) ? 2'b11 :
                 ((e.kind == K_MWR) || (e.kind == K_IOWR)) ? 2'b01 : 2'b10;
        tst    = ((e.kind == K_FETCH) ? 4 : 3) + e.waits;
        chk(cnt == 2 * tst, "R3 R8 accept-to-done clocks", cnt, 2 * tst);
        chk(ale_cnt == 2, "R2 ale width", ale_cnt, 2);
        chk(seen_addr == e_addr, "R2 R5 address phase", seen_addr, e_addr);
        chk(seen_st == {e_stat, e_io}, "R4 R5 status and io_m", seen_st, {e_stat, e_io});
        chk(hl_cnt == 0, "R9 hlda during cycle", hl_cnt, 0);
        if (e_stat[0] && !e_stat[1]) begin
          chk(wr_cnt == 2 * (2 + e.waits), "R7 R8 write strobe clocks", wr_cnt, 2 * (2 + e.waits));
          chk(wd_seen == e.wdata, "R7 write data", wd_seen, e.wdata);
          chk(wd_bad == 0, "R7 lanes driven", wd_bad, 0);
          chk(rd_cnt == 0, "R7 read strobe idle", rd_cnt, 0);
        end else begin
          chk(rsp_rdata == tgt_data(e_addr, e_io), "R6 read data", rsp_rdata, tgt_data(e_addr, e_io));
          chk(rd_cnt == 2 * (2 + e.waits), "R6 R8 read strobe clocks", rd_cnt, 2 * (2 + e.waits));
          chk(wr_cnt == 0, "R6 write strobe idle", wr_cnt, 0);
          chk(oe_cnt == 2, "R6 R11 lanes released after T1", oe_cnt, 2);
        end
      end
      busy = 1'b0;
    end
  end

  task automatic issue(input logic [2:0] k, input logic [15:0] a, input logic [7:0] d, input int w);
    exp_t x;
    while (busy) @(negedge clk);
    x.kind = k; x.addr = a; x.wdata = d; x.waits = w;
    wait_k = w;
    q.push_back(x);
    req_kind = k; req_addr = a; req_wdata = d; req_valid = 1'b1;
    do @(negedge clk); while (!req_accept);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_all();
    rst_n = 1'b0; hold = 1'b0; req_valid = 1'b0;
    req_kind = 3'd0; req_addr = 16'h0; req_wdata = 8'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ale == 1'b0 && rd_n && wr_n, "R1 strobes idle", {ale, rd_n, wr_n}, 3'b011);
    chk(!ad_oe && bus_oe && !hlda, "R1 enables", {ad_oe, bus_oe, hlda}, 3'b010);
    chk({s1, s0, io_m} == 3'b000, "R1 status", {s1, s0, io_m}, 0);
    chk(!req_accept && !rsp_done, "R1 pulses", {req_accept, rsp_done}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(!req_accept && rd_n && wr_n && !ale, "R1 idle after release", {req_accept, rd_n, wr_n, ale}, 4'b0110);

    // each kind, no waits
    issue(K_FETCH, 16'h1234, 8'h00, 0);
    issue(K_MRD,   16'hC200, 8'h00, 0);
    issue(K_MWR,   16'h8001, 8'h5A, 0);
    issue(K_IORD,  16'h0080, 8'h00, 0);
    issue(K_IOWR,  16'hFF41, 8'h39, 0);
    // R8: wait states on each kind
    issue(K_FETCH, 16'hFFFF, 8'h00, 2);
    issue(K_MRD,   16'h0000, 8'h00, 1);
    issue(K_MWR,   16'hA5C3, 8'hC3, 3);
    issue(K_IORD,  16'h12F7, 8'h00, 1);
    issue(K_IOWR,  16'h0000, 8'hFF, 2);
    issue(K_FETCH, 16'h0001, 8'h00, 0);
    wait_idle();

    // R9 R10: hold in the middle of a stretched read
    issue(K_MRD, 16'h4C7E, 8'h00, 2);
    hold = 1'b1;
    wait_idle();
    repeat (2) @(negedge clk);
    chk(hlda == 1'b1, "R9 hlda after cycle end", hlda, 1);
    chk(!bus_oe && !ad_oe, "R9 drivers released", {bus_oe, ad_oe}, 0);
    fork
      issue(K_FETCH, 16'h2050, 8'h00, 0);
      begin
        for (int i = 0; i < 8; i++) begin
          @(negedge clk);
          chk(!req_accept, "R9 no accept under hold", req_accept, 0);
        end
        chk(hlda && !bus_oe, "R9 hold kept", {hlda, bus_oe}, 2'b10);
        hold = 1'b0;
        repeat (4) @(negedge clk);
        chk(!hlda && bus_oe, "R10 hlda dropped", {hlda, bus_oe}, 2'b01);
      end
    join
    wait_idle();
    chk(q.size() == 0, "R10 queued request completed", q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule